// File: doc/BRIEF.md
# Guarded Nonvolatile Write Sequencer

This block holds the control registers that a CPU uses to start program cycles on an on-chip nonvolatile data memory. Software loads an address register and a data register. It then sets an arm bit, and within a short window it sets a start bit. Only when that two-step sequence is followed does the block launch an operation. It then holds a busy indication for the whole programming time and issues one erase and/or write command, with the captured address and data, to the memory.

The operation kind comes from a two-bit mode field: atomic erase-then-write, erase only, write only, or a reserved code that does nothing. The atomic kind takes roughly twice as long as the other two, and both durations are parameters counted in clock cycles. A level interrupt tells software that the memory is ready for another operation. A flash self-programming busy input blocks any launch while the CPU is rewriting its program memory.

Top module: `nvmseq_top`

## Requirements
- R1: After a synchronous reset with no operation running, the control readback is 0x00, the address and data readbacks are 0, the ready interrupt is low and no command is issued. Control layout: bit0 busy/start, bit1 arm, bit2 interrupt enable, bits 5:4 mode, all other bits read 0.
- R2: A control write with bit1 set arms the block. The arm bit reads 1 for exactly ARM_WIN cycles (default 4) after that write, then clears without any further write.
- R3: A control write with bit0 = 1 and bit1 = 0, made while the arm bit reads 1, sets busy from the next cycle. The same write made while the arm bit reads 0 leaves busy at 0.
- R4: A single control write with both bit0 and bit1 set does not launch an operation. It only arms the block.
- R5: While flash_busy is high, a start write is refused and busy stays 0.
- R6: Busy stays 1 for exactly T_ATOMIC cycles in mode 00 and for exactly T_SINGLE cycles in modes 01, 10 and 11, then clears itself.
- R7: In the cycle after a launch, mem_cmd_valid is 1 for one cycle. Its flags are erase = 1 and write = 1 for mode 00, erase only for mode 01, and write only for mode 10. Its address and data are the register values held when the start write was made. Mode 11 issues no command.
- R8: While busy reads 1, control writes leave the mode field unchanged. The interrupt enable in the same write is still updated.
- R9: A reset while busy reads 1 neither clears the mode field nor stops the operation. A reset while idle returns the mode field to 00.
- R10: ready_irq is 1 exactly when busy is 0, the interrupt enable is 1 and gie is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | AW | Address register write value |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | DW | Data register write value |
| flash_busy | input | 1 | Flash self-programming in progress |
| gie | input | 1 | Global interrupt enable |
| ctrl_rdata | output | 8 | Control register readback |
| addr_rdata | output | AW | Address register readback |
| data_rdata | output | DW | Data register readback |
| ready_irq | output | 1 | Ready interrupt level |
| mem_cmd_valid | output | 1 | One-cycle command strobe to the memory |
| mem_cmd_erase | output | 1 | Command erases the location |
| mem_cmd_write | output | 1 | Command writes the location |
| mem_cmd_addr | output | AW | Command address |
| mem_cmd_data | output | DW | Command data |

## Verification
The bench builds the block with T_ATOMIC = 12 and T_SINGLE = 7 in place of the default tens of thousands of cycles. With these values every mode can run to completion many times, and the exact busy length of each mode can be counted cycle by cycle. ARM_WIN keeps its value of 4, so a start on the fourth cycle after arming and a refused start on the fifth can both be driven. AW = 6 shows that the address path follows its parameter.

// File: rtl/nvmseq_pkg.sv
package nvmseq_pkg;

    typedef enum logic [1:0] {
        MODE_ERASE_WRITE = 2'b00,
        MODE_ERASE       = 2'b01,
        MODE_WRITE       = 2'b10,
        MODE_RSVD        = 2'b11
    } nv_mode_e;

    // control register bit positions
    localparam int CTL_START = 0;
    localparam int CTL_ARM   = 1;
    localparam int CTL_IRQEN = 2;
    localparam int CTL_MODE  = 4;

    typedef struct packed {
        logic erase;
        logic write;
    } nv_op_t;

    function automatic nv_op_t op_of(nv_mode_e m);
        nv_op_t o;
        unique case (m)
            MODE_ERASE_WRITE: o = '{erase: 1'b1, write: 1'b1};
            MODE_ERASE:       o = '{erase: 1'b1, write: 1'b0};
            MODE_WRITE:       o = '{erase: 1'b0, write: 1'b1};
            default:          o = '{erase: 1'b0, write: 1'b0};
        endcase
        return o;
    endfunction

    function automatic logic is_long(nv_mode_e m);
        return m == MODE_ERASE_WRITE;
    endfunction

endpackage

// File: rtl/nvmseq_arm.sv
module nvmseq_arm #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic armed
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(WIN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign armed = (cnt_q != '0);

    // R2
    arm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(load));

endmodule

// File: rtl/nvmseq_prog.sv
module nvmseq_prog #(
    parameter int T_LONG  = 68000,
    parameter int T_SHORT = 36000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic long_op,
    output logic busy
);
    localparam int CW = (T_LONG > 1) ? $clog2(T_LONG) : 1;

    // the timer runs through reset so that an operation in progress completes
    logic          busy_q = 1'b0;
    logic [CW-1:0] left_q = '0;

    always_ff @(posedge clk) begin
        if (launch) begin
            busy_q <= 1'b1;
            left_q <= long_op ? CW'(T_LONG - 1) : CW'(T_SHORT - 1);
        end else if (busy_q) begin
            if (left_q == '0)
                busy_q <= 1'b0;
            else
                left_q <= left_q - 1'b1;
        end
    end

    assign busy = busy_q;

    // R3 R6
    launch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy_q);

endmodule

// File: rtl/nvmseq_top.sv
module nvmseq_top
    import nvmseq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int ARM_WIN  = 4,
    parameter int T_ATOMIC = 68000,
    parameter int T_SINGLE = 36000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    input  logic          flash_busy,
    input  logic          gie,
    output logic [7:0]    ctrl_rdata,
    output logic [AW-1:0] addr_rdata,
    output logic [DW-1:0] data_rdata,
    output logic          ready_irq,
    output logic          mem_cmd_valid,
    output logic          mem_cmd_erase,
    output logic          mem_cmd_write,
    output logic [AW-1:0] mem_cmd_addr,
    output logic [DW-1:0] mem_cmd_data
);
    nv_mode_e      mode_q;
    nv_mode_e      wmode;
    nv_op_t        op_q;
    logic          irqen_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          cmd_valid_q;
    logic [AW-1:0] cmd_addr_q;
    logic [DW-1:0] cmd_data_q;
    logic          armed;
    logic          busy;
    logic          arm_load;
    logic          launch;

    assign wmode    = nv_mode_e'(ctrl_wdata[CTL_MODE +: 2]);
    assign arm_load = ctrl_we & ctrl_wdata[CTL_ARM];
    assign launch   = ~rst & ctrl_we & ctrl_wdata[CTL_START] & ~ctrl_wdata[CTL_ARM]
                    & armed & ~busy & ~flash_busy;

    nvmseq_arm #(.WIN(ARM_WIN)) u_arm (
        .clk   (clk),
        .rst   (rst),
        .load  (arm_load),
        .armed (armed)
    );

    nvmseq_prog #(.T_LONG(T_ATOMIC), .T_SHORT(T_SINGLE)) u_prog (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .long_op (is_long(wmode)),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irqen_q     <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            cmd_valid_q <= 1'b0;
            if (!busy)
                mode_q <= MODE_ERASE_WRITE;
        end else begin
            if (ctrl_we) begin
                irqen_q <= ctrl_wdata[CTL_IRQEN];
                if (!busy)
                    mode_q <= wmode;
            end
            if (addr_we)
                addr_q <= addr_wdata;
            if (data_we)
                data_q <= data_wdata;
            cmd_valid_q <= launch && (wmode != MODE_RSVD);
        end
        if (launch) begin
            op_q       <= op_of(wmode);
            cmd_addr_q <= addr_q;
            cmd_data_q <= data_q;
        end
    end

    assign ctrl_rdata    = {2'b00, mode_q, 1'b0, irqen_q, armed, busy};
    assign addr_rdata    = addr_q;
    assign data_rdata    = data_q;
    assign ready_irq     = ~busy & irqen_q & gie;
    assign mem_cmd_valid = cmd_valid_q;
    assign mem_cmd_erase = op_q.erase;
    assign mem_cmd_write = op_q.write;
    assign mem_cmd_addr  = cmd_addr_q;
    assign mem_cmd_data  = cmd_data_q;

    // R8 R9
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    // R7
    cmd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> busy);

    // R5
    flash_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(flash_busy));

    // R3
    start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));

endmodule

// File: tb/nvmseq_top_test.sv
module nvmseq_top_test;
    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int DW     = 8;
    localparam int T_AT   = 12;
    localparam int T_SG   = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctrl_we = 1'b0;
    logic [7:0]    ctrl_wdata = '0;
    logic          addr_we = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic          data_we = 1'b0;
    logic [DW-1:0] data_wdata = '0;
    logic          flash_busy = 1'b0;
    logic          gie = 1'b0;
    logic [7:0]    ctrl_rdata;
    logic [AW-1:0] addr_rdata;
    logic [DW-1:0] data_rdata;
    logic          ready_irq;
    logic          mem_cmd_valid, mem_cmd_erase, mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [DW-1:0] mem_cmd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    nvmseq_top #(.AW(AW), .DW(DW), .ARM_WIN(4), .T_ATOMIC(T_AT), .T_SINGLE(T_SG)) uut (
        .clk(clk), .rst(rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .flash_busy(flash_busy), .gie(gie),
        .ctrl_rdata(ctrl_rdata), .addr_rdata(addr_rdata), .data_rdata(data_rdata),
        .ready_irq(ready_irq),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_erase(mem_cmd_erase),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_data(mem_cmd_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated on every clock and compared shortly after
    int          m_arm = 0;
    bit          m_busy = 0;
    int          m_left = 0;
    bit [1:0]    m_mode = 0;
    bit          m_irqen = 0;
    bit [AW-1:0] m_addr = 0;
    bit [DW-1:0] m_data = 0;
    bit          m_cv = 0, m_ce = 0, m_cw = 0;
    bit [AW-1:0] m_ca = 0;
    bit [DW-1:0] m_cd = 0;

    always @(posedge clk) begin
        bit ob;
        bit go;
        bit [1:0] wm;
        ob = m_busy;
        wm = ctrl_wdata[5:4];
        go = !rst && ctrl_we && ctrl_wdata[0] && !ctrl_wdata[1] && m_arm > 0 && !ob && !flash_busy;
        if (ob) begin
            if (m_left == 0) m_busy = 0;
            else m_left--;
        end
        if (rst) begin
            m_arm = 0; m_irqen = 0; m_addr = 0; m_data = 0; m_cv = 0;
            if (!ob) m_mode = 0;
        end else begin
            m_cv = go && wm != 2'd3;
            if (go) begin
                m_ce = (wm != 2'd2);
                m_cw = (wm != 2'd1);
                m_ca = m_addr;
                m_cd = m_data;
                m_busy = 1;
                m_left = ((wm == 2'd0) ? T_AT : T_SG) - 1;
            end
            if (ctrl_we) begin
                m_irqen = ctrl_wdata[2];
                if (!ob) m_mode = wm;
            end
            if (ctrl_we && ctrl_wdata[1]) m_arm = 4;
            else if (m_arm > 0) m_arm--;
            if (addr_we) m_addr = addr_wdata;
            if (data_we) m_data = data_wdata;
        end
        #2;
        if (!done) begin
            chk(ctrl_rdata[0] == m_busy, "R6 busy", ctrl_rdata[0], m_busy);
            chk(ctrl_rdata[1] == (m_arm > 0), "R2 arm", ctrl_rdata[1], (m_arm > 0));
            chk(ctrl_rdata[5:4] == m_mode, "R8 mode", ctrl_rdata[5:4], m_mode);
            chk(ctrl_rdata[2] == m_irqen, "R10 irq enable", ctrl_rdata[2], m_irqen);
            chk({ctrl_rdata[7:6], ctrl_rdata[3]} == 3'b0, "R1 reserved bits", ctrl_rdata, 0);
            chk(ready_irq == (!m_busy && m_irqen && gie), "R10 ready_irq", ready_irq,
                (!m_busy && m_irqen && gie));
            chk(mem_cmd_valid == m_cv, "R7 cmd valid", mem_cmd_valid, m_cv);
            if (m_cv && mem_cmd_valid)
                chk({mem_cmd_erase, mem_cmd_write, mem_cmd_addr, mem_cmd_data} ==
                    {m_ce, m_cw, m_ca, m_cd}, "R7 cmd payload",
                    {mem_cmd_erase, mem_cmd_write, mem_cmd_addr, mem_cmd_data},
                    {m_ce, m_cw, m_ca, m_cd});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic wr_addr(input logic [AW-1:0] v);
        addr_we = 1'b1; addr_wdata = v;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic wr_data(input logic [DW-1:0] v);
        data_we = 1'b1; data_wdata = v;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic wait_idle(input int exp_len, input string tag);
        int n = 0;
        while (ctrl_rdata[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        if (exp_len > 0) chk(n == exp_len, tag, n, exp_len);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        chk(ctrl_rdata == 8'h00, "R1 ctrl after reset", ctrl_rdata, 8'h00);
        chk(addr_rdata == 0 && data_rdata == 0, "R1 addr/data after reset",
            {addr_rdata, data_rdata}, 0);
        chk(!ready_irq && !mem_cmd_valid, "R1 outputs after reset",
            {ready_irq, mem_cmd_valid}, 0);

        // R3 R6 R7: atomic erase+write, start right after arming
        wr_addr(6'd5);
        wr_data(8'hA5);
        wr_ctrl(8'h02);
        chk(ctrl_rdata[1], "R2 arm set", ctrl_rdata[1], 1);
        wr_ctrl(8'h05);
        chk(ctrl_rdata[0], "R3 launch", ctrl_rdata[0], 1);
        chk(mem_cmd_valid && mem_cmd_erase && mem_cmd_write && mem_cmd_addr == 5 &&
            mem_cmd_data == 8'hA5, "R7 atomic command",
            {mem_cmd_valid, mem_cmd_erase, mem_cmd_write, mem_cmd_addr, mem_cmd_data},
            {3'b111, 6'd5, 8'hA5});
        wait_idle(T_AT, "R6 atomic duration");

        // R2 R3: start on the fourth cycle after arming is accepted (erase only)
        wr_addr(6'd9);
        wr_ctrl(8'h02);
        idle(3);
        wr_ctrl(8'h11);
        chk(ctrl_rdata[0], "R3 start at window end", ctrl_rdata[0], 1);
        chk(mem_cmd_valid && mem_cmd_erase && !mem_cmd_write, "R7 erase-only flags",
            {mem_cmd_valid, mem_cmd_erase, mem_cmd_write}, 3'b110);
        wait_idle(T_SG, "R6 erase-only duration");

        // R2 R3: fifth cycle is too late
        wr_ctrl(8'h02);
        idle(4);
        chk(!ctrl_rdata[1], "R2 arm expired", ctrl_rdata[1], 0);
        wr_ctrl(8'h01);
        chk(!ctrl_rdata[0], "R3 late start ignored", ctrl_rdata[0], 0);

        // R3: start without arm
        wr_ctrl(8'h01);
        chk(!ctrl_rdata[0] && !mem_cmd_valid, "R3 unarmed start ignored",
            {ctrl_rdata[0], mem_cmd_valid}, 0);

        // R4: arm and start in one write
        wr_ctrl(8'h03);
        chk(!ctrl_rdata[0] && ctrl_rdata[1], "R4 combined write", ctrl_rdata[1:0], 2'b10);
        idle(4);

        // R5: flash busy blocks launch
        flash_busy = 1'b1;
        wr_ctrl(8'h02);
        wr_ctrl(8'h01);
        chk(!ctrl_rdata[0], "R5 flash busy refusal", ctrl_rdata[0], 0);
        flash_busy = 1'b0;
        idle(4);

        // R8 R10: mode locked while busy, irq enable still written
        gie = 1'b1;
        wr_data(8'h3C);
        wr_ctrl(8'h02);
        wr_ctrl(8'h21);
        chk(mem_cmd_valid && !mem_cmd_erase && mem_cmd_write && mem_cmd_data == 8'h3C,
            "R7 write-only command", {mem_cmd_valid, mem_cmd_erase, mem_cmd_write, mem_cmd_data},
            {3'b101, 8'h3C});
        wr_ctrl(8'h34);
        wr_addr(6'd33);
        chk(ctrl_rdata[5:4] == 2'b10, "R8 mode locked", ctrl_rdata[5:4], 2'b10);
        chk(ctrl_rdata[2] && !ready_irq, "R10 irq held low while busy",
            {ctrl_rdata[2], ready_irq}, 2'b10);
        wait_idle(0, "");
        chk(ready_irq, "R10 irq when idle", ready_irq, 1);
        gie = 1'b0;
        idle(1);
        chk(!ready_irq, "R10 irq masked by gie", ready_irq, 0);

        // R7 R6: reserved mode runs without a command
        wr_ctrl(8'h02);
        wr_ctrl(8'h31);
        chk(ctrl_rdata[0] && !mem_cmd_valid, "R7 reserved no command",
            {ctrl_rdata[0], mem_cmd_valid}, 2'b10);
        wait_idle(T_SG, "R6 reserved duration");

        // R9: reset during programming
        wr_ctrl(8'h02);
        wr_ctrl(8'h11);
        idle(1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk(ctrl_rdata[0] && ctrl_rdata[5:4] == 2'b01, "R9 reset while busy",
            {ctrl_rdata[0], ctrl_rdata[5:4]}, 3'b101);
        wait_idle(T_SG - 3, "R9 operation continues");
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk(ctrl_rdata == 8'h00, "R9 reset while idle", ctrl_rdata, 8'h00);
        idle(2);
        finish_run();
    end
endmodule